// File: doc/BRIEF.md
# Serial Transmitter with Rate Divider

This block turns words handed over by a host into an asynchronous serial stream on a single line. Each word is wrapped in a frame: a low start bit first, then the data bits least significant first, then an optional parity bit, then a high stop bit. The host supplies the parity value itself, so the block does not compute it. The data part is either the full word or the word less its top bit.

A 4-bit rate code selects a divisor for the input clock. The divided tick runs at sixteen times the bit rate, so every bit lasts sixteen ticks. The line can be driven as plain NRZ levels, or in an infrared pulse style. In the pulse style, a zero bit becomes a short high pulse at the start of the bit and a one bit leaves the line low.

A one-word holding buffer lets the host queue the next word while a frame is still going out. Frames then follow each other with no gap. A shutdown input empties the block at once, and a frame in progress is abandoned. The reset input asserts asynchronously and is released synchronously inside the block.

Top module: `sertx_top`

## Requirements
- R1: A bit lasts 16*D clock cycles. D is 2^c for rate code c from 0 to 7, and 3*2^(c-8) for c from 8 to 15.
- R2: In NRZ mode (cfg_irda=0) a frame is sent in this order: start bit 0, then the data bits with bit 0 first, then the parity bit if enabled, then stop bit 1. The line rests at 1.
- R3: With cfg_short=1 only load_data[6:0] is sent, so the frame has one data bit fewer and load_data[7] has no effect on tx.
- R4: The parity bit is present only when cfg_par_on=1, and its value is load_par. With cfg_par_on=0 the stop bit follows the last data bit directly.
- R5: In pulse mode (cfg_irda=1) a zero bit drives tx high for the first 3*D cycles of the bit and low for the rest of it. A one bit and the idle line are low.
- R6: A load is taken only when buf_empty=1, and buf_empty falls after that edge. A load while buf_empty=0 is ignored and never reaches tx.
- R7: A buffered word moves into the shifter on the edge after it is loaded if the line is idle, or on the edge that ends the stop bit of the running frame. buf_empty rises and busy is 1 from that edge, and back-to-back frames leave no idle cycle.
- R8: While shdn=1, tx is at the idle level in the same cycle. From the next edge busy=0 and buf_empty=1, any queued word is discarded, and loads are ignored.
- R9: After reset, tx=1, busy=0 and buf_empty=1.
- R10: The rate code, the short-word setting and the parity enable are captured when a word enters the shifter. Changing them during a frame does not alter that frame. cfg_irda acts immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| load | input | 1 | Strobe offering load_data and load_par to the buffer |
| load_data | input | 8 | Word to send |
| load_par | input | 1 | Parity bit value to send with the word |
| cfg_rate | input | 4 | Rate code selecting the clock divisor |
| cfg_short | input | 1 | 1: send 7 data bits, 0: send 8 |
| cfg_par_on | input | 1 | 1: append the parity bit |
| cfg_irda | input | 1 | 1: pulse line coding, 0: NRZ |
| shdn | input | 1 | Shutdown; aborts and empties the block |
| tx | output | 1 | Serial line |
| busy | output | 1 | A frame is being shifted out |
| buf_empty | output | 1 | Holding buffer can take a word |

## Verification
If the divider or the bit counter goes wrong, the start bit already shows it as a wrong run length on tx, within the first 16*D cycles of a frame. If the frame vector or the remaining-bit count is wrong, a data, parity or stop level appears in the wrong bit slot, or busy falls early or late. A buffer flag that has gone wrong shows up either as a frame the host never committed or as a missing frame, and the gap or overlap appears at the next stop-bit boundary. A cycle-level model checks tx, busy and buf_empty on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int RATE_W = 4;
  localparam int CNT_W  = 9;

  typedef struct packed {
    logic              short_word;
    logic              par_on;
    logic [RATE_W-1:0] rate;
  } fmt_t;

  // low codes: powers of two; high codes: three times a power of two
  function automatic logic [CNT_W-1:0] rate_divisor(input logic [RATE_W-1:0] code);
    logic [CNT_W-1:0] base;
    base = code[RATE_W-1] ? CNT_W'(3) : CNT_W'(1);
    return base << code[RATE_W-2:0];
  endfunction
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last = rate_divisor(rate) - CNT_W'(1);
    tick = run && (cnt_q == last);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: divider restarts after each tick and while idle
  a_r1_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
  a_r1_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last));
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int FRAME_W = DATA_W + 3,
  localparam int LEFT_W  = $clog2(FRAME_W),
  localparam int SUB_W   = $clog2(OVS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_par,
  input  fmt_t              fmt_in,
  input  logic              tick,
  output logic              busy,
  output logic              buf_empty,
  output logic              line_bit,
  output logic [SUB_W-1:0]  sub_o,
  output logic [RATE_W-1:0] rate_o
);
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d,
                                                   input logic p, input fmt_t f);
    logic [FRAME_W-1:0] fr;
    fr    = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (!(f.short_word && i == DATA_W-1)) fr[i+1] = d[i];
    if (f.par_on) begin
      if (f.short_word) fr[DATA_W]   = p;
      else              fr[DATA_W+1] = p;
    end
    return fr;
  endfunction

  function automatic logic [LEFT_W-1:0] last_index(input fmt_t f);
    return LEFT_W'(DATA_W + 1) - LEFT_W'(f.short_word) + LEFT_W'(f.par_on);
  endfunction

  logic                buf_full_q, buf_full_d;
  logic [DATA_W-1:0]   buf_data_q, buf_data_d;
  logic                buf_par_q,  buf_par_d;
  logic                busy_q,     busy_d;
  logic [FRAME_W-1:0]  shift_q,    shift_d;
  logic [LEFT_W-1:0]   left_q,     left_d;
  logic [SUB_W-1:0]    sub_q,      sub_d;
  logic [RATE_W-1:0]   rate_q,     rate_d;
  logic                bit_end, frame_end, xfer, take;

  always_comb begin
    bit_end   = tick && (sub_q == SUB_W'(OVS-1));
    frame_end = bit_end && (left_q == '0);
    xfer      = buf_full_q && (!busy_q || frame_end);
    take      = load && !buf_full_q;
  end

  always_comb begin
    buf_full_d = buf_full_q;
    buf_data_d = buf_data_q;
    buf_par_d  = buf_par_q;
    busy_d     = busy_q;
    shift_d    = shift_q;
    left_d     = left_q;
    sub_d      = sub_q;
    rate_d     = rate_q;
    if (shdn) begin
      busy_d     = 1'b0;
      buf_full_d = 1'b0;
      sub_d      = '0;
    end else begin
      if (busy_q && tick) sub_d = bit_end ? '0 : sub_q + SUB_W'(1);
      if (bit_end && !frame_end) begin
        shift_d = {1'b1, shift_q[FRAME_W-1:1]};
        left_d  = left_q - LEFT_W'(1);
      end
      if (frame_end) busy_d = 1'b0;
      if (xfer) begin
        busy_d     = 1'b1;
        shift_d    = pack_frame(buf_data_q, buf_par_q, fmt_in);
        left_d     = last_index(fmt_in);
        sub_d      = '0;
        rate_d     = fmt_in.rate;
        buf_full_d = 1'b0;
      end
      if (take) begin
        buf_full_d = 1'b1;
        buf_data_d = load_data;
        buf_par_d  = load_par;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full_q <= 1'b0;
      buf_data_q <= '0;
      buf_par_q  <= 1'b0;
      busy_q     <= 1'b0;
      shift_q    <= '1;
      left_q     <= '0;
      sub_q      <= '0;
      rate_q     <= '0;
    end else begin
      buf_full_q <= buf_full_d;
      buf_data_q <= buf_data_d;
      buf_par_q  <= buf_par_d;
      busy_q     <= busy_d;
      shift_q    <= shift_d;
      left_q     <= left_d;
      sub_q      <= sub_d;
      rate_q     <= rate_d;
    end
  end

  always_comb begin
    busy      = busy_q;
    buf_empty = !buf_full_q;
    line_bit  = shift_q[0];
    sub_o     = sub_q;
    rate_o    = rate_q;
  end

  // R8: shutdown flushes shifter and buffer on the next edge
  a_r8_shdn_flush: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> (!busy_q && !buf_full_q));
  // R6: a held word is not overwritten while the frame runs
  a_r6_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full_q && busy_q && !bit_end && !shdn) |=> (buf_full_q && $stable(buf_data_q)));
  // R7: a frame starts only by emptying the buffer
  a_r7_start_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !buf_full_q);
  // R4: remaining-bit count never exceeds the longest frame
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q <= LEFT_W'(DATA_W + 2)));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int PULSE  = 3,
  localparam int SUB_W = $clog2(OVS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_par,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_short,
  input  logic              cfg_par_on,
  input  logic              cfg_irda,
  input  logic              shdn,
  output logic              tx,
  output logic              busy,
  output logic              buf_empty
);
  logic [1:0]        rst_sync;
  logic              rst_i;
  fmt_t              fmt;
  logic              tick, line_bit;
  logic [SUB_W-1:0]  sub;
  logic [RATE_W-1:0] rate_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  always_comb fmt = '{short_word: cfg_short, par_on: cfg_par_on, rate: cfg_rate};

  sertx_baud u_baud (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (busy),
    .rate  (rate_run),
    .tick  (tick)
  );

  sertx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_i),
    .shdn      (shdn),
    .load      (load),
    .load_data (load_data),
    .load_par  (load_par),
    .fmt_in    (fmt),
    .tick      (tick),
    .busy      (busy),
    .buf_empty (buf_empty),
    .line_bit  (line_bit),
    .sub_o     (sub),
    .rate_o    (rate_run)
  );

  // line coding: NRZ level, or short pulse for zero bits
  always_comb begin
    if (shdn || !busy)  tx = !cfg_irda;
    else if (cfg_irda)  tx = !line_bit && (sub < SUB_W'(PULSE));
    else                tx = line_bit;
  end

  // R8: shutdown forces the rest level in the same cycle
  a_r8_shdn_rest: assert property (@(posedge clk) disable iff (!rst_i)
    shdn |-> (tx == !cfg_irda));
  // R5: pulse mode keeps the line dark for ones and when idle
  a_r5_dark_idle: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_irda && !busy) |-> !tx);
  a_r5_dark_one: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_irda && busy && line_bit) |-> !tx);
  // R2: NRZ line rests high
  a_r2_rest_high: assert property (@(posedge clk) disable iff (!rst_i)
    (!cfg_irda && !busy) |-> tx);
endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OVS   = 16;
  localparam int PULSE = 3;

  logic       clk, rst_n, load, load_par, cfg_short, cfg_par_on, cfg_irda, shdn;
  logic [7:0] load_data;
  logic [3:0] cfg_rate;
  logic       tx, busy, buf_empty;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  sertx_top dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data), .load_par(load_par),
    .cfg_rate(cfg_rate), .cfg_short(cfg_short), .cfg_par_on(cfg_par_on),
    .cfg_irda(cfg_irda), .shdn(shdn), .tx(tx), .busy(busy), .buf_empty(buf_empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int div_of(input int code);
    return (code < 8) ? (1 << code) : (3 << (code - 8));
  endfunction

  function automatic logic [10:0] frame_bits(input logic [7:0] d, input logic p,
                                             input logic sh, input logic pe);
    logic [10:0] f;
    int len;
    len  = sh ? 7 : 8;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < len; i++) f[1+i] = d[i];
    if (pe) f[1+len] = p;
    return f;
  endfunction

  function automatic int frame_len(input logic sh, input logic pe);
    return 2 + (sh ? 7 : 8) + (pe ? 1 : 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // ---------------- reference model ----------------
  int          m_busy, m_full, m_idx, m_nbits, m_k, m_div;
  logic [7:0]  m_bdata;
  logic        m_bpar;
  logic [10:0] m_fr;

  always @(posedge clk or negedge rst_n) begin
    int take, xfer;
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_idx = 0; m_nbits = 0; m_k = 0; m_div = 1;
      m_bdata = '0; m_bpar = 1'b0; m_fr = '1;
    end else begin
      take = (load && !m_full) ? 1 : 0;
      if (shdn) begin
        m_busy = 0; m_full = 0;
      end else begin
        xfer = 0;
        if (m_busy != 0) begin
          m_k++;
          if (m_k == OVS * m_div) begin
            m_k = 0;
            m_idx++;
            if (m_idx == m_nbits) begin
              m_busy = 0;
              if (m_full != 0) xfer = 1;
            end
          end
        end else if (m_full != 0) xfer = 1;
        if (xfer != 0) begin
          m_fr    = frame_bits(m_bdata, m_bpar, cfg_short, cfg_par_on);
          m_nbits = frame_len(cfg_short, cfg_par_on);
          m_div   = div_of(int'(cfg_rate));
          m_busy  = 1; m_idx = 0; m_k = 0; m_full = 0;
        end
        if (take != 0) begin
          m_full = 1; m_bdata = load_data; m_bpar = load_par;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int exp_tx;
    string tag;
    if (shdn || m_busy == 0) exp_tx = cfg_irda ? 0 : 1;
    else if (cfg_irda)       exp_tx = (m_fr[m_idx] == 1'b0 && m_k < PULSE * m_div) ? 1 : 0;
    else                     exp_tx = int'(m_fr[m_idx]);
    tag = shdn ? "R8 tx" : (cfg_irda ? "R5 tx" : "R2 tx");
    chk(tag, int'(tx), exp_tx);
    chk("R7 busy", int'(busy), m_busy);
    chk("R6 buf_empty", int'(buf_empty), (m_full == 0) ? 1 : 0);
  end

  // length of the last continuous busy run
  int busy_run = 0;
  int last_run = 0;
  always @(negedge clk) begin
    if (busy === 1'b1) busy_run++;
    else begin
      if (busy_run != 0) last_run = busy_run;
      busy_run = 0;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_load(input logic [7:0] d, input logic p);
    step();
    load = 1'b1; load_data = d; load_par = p;
    step();
    load = 1'b0;
  endtask

  task automatic capture(input int div, input bit swap,
                         output logic [10:0] got, output int len);
    int c;
    got = '1;
    c = 0;
    @(negedge clk);
    while (busy !== 1'b1 && c < 20000) begin @(negedge clk); c++; end
    c = 0;
    while (busy === 1'b1 && c < 20000) begin
      if ((c % (OVS*div)) == (OVS/2)*div && (c / (OVS*div)) < 11)
        got[c / (OVS*div)] = tx;
      if (swap && c == 20) begin
        cfg_short = 1'b1; cfg_par_on = 1'b0; cfg_rate = 4'd3;
      end
      c++;
      @(negedge clk);
    end
    len = c;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [10:0] got;
    int len, cnt;
    rst_n = 1'b0; load = 1'b0; load_data = '0; load_par = 1'b0;
    cfg_rate = '0; cfg_short = 1'b0; cfg_par_on = 1'b0; cfg_irda = 1'b0; shdn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 tx in reset", int'(tx), 1);
    chk("R9 busy in reset", int'(busy), 0);
    chk("R9 buf_empty in reset", int'(buf_empty), 1);
    step(); rst_n = 1'b1;
    idle(5);
    @(negedge clk);
    chk("R9 tx after reset", int'(tx), 1);

    // R1: start bit length for every rate code, then abort
    for (int code = 0; code < 16; code++) begin
      cfg_rate = 4'(code);
      pulse_load(8'hFF, 1'b0);
      cnt = 0;
      @(negedge clk);
      while (busy !== 1'b1 && cnt < 50) begin @(negedge clk); cnt++; end
      cnt = 0;
      while (tx === 1'b0 && cnt < 10000) begin cnt++; @(negedge clk); end
      chk($sformatf("R1 start bit cycles code %0d", code), cnt, OVS * div_of(code));
      step(); shdn = 1'b1;
      step(); shdn = 1'b0;
      @(negedge clk);
      chk("R8 busy after abort", int'(busy), 0);
    end
    cfg_rate = 4'd0;
    idle(3);

    // R2 R4: full word with parity 1
    cfg_par_on = 1'b1;
    pulse_load(8'hA5, 1'b1);
    capture(1, 1'b0, got, len);
    chk("R2 frame bits A5", int'(got), int'(frame_bits(8'hA5, 1'b1, 1'b0, 1'b1)));
    chk("R4 frame length with parity", len, 11 * OVS);

    // R4: parity value taken from load_par
    pulse_load(8'hFF, 1'b0);
    capture(1, 1'b0, got, len);
    chk("R4 parity slot zero", int'(got[9]), 0);
    chk("R4 stop after parity", int'(got[10]), 1);

    // R4: parity off
    cfg_par_on = 1'b0;
    pulse_load(8'h3C, 1'b0);
    capture(1, 1'b0, got, len);
    chk("R4 no parity bits", int'(got), int'(frame_bits(8'h3C, 1'b0, 1'b0, 1'b0)));
    chk("R4 no parity length", len, 10 * OVS);

    // R3: short word drops bit 7
    cfg_short = 1'b1;
    pulse_load(8'h55, 1'b0);
    capture(1, 1'b0, got, len);
    chk("R3 stop in slot 8", int'(got[8]), 1);
    chk("R3 short frame length", len, 9 * OVS);
    cfg_short = 1'b0;

    // R10: settings changed mid-frame do not alter it
    cfg_par_on = 1'b1;
    pulse_load(8'h55, 1'b0);
    capture(1, 1'b1, got, len);
    chk("R10 frame kept format", int'(got), int'(frame_bits(8'h55, 1'b0, 1'b0, 1'b1)));
    chk("R10 frame kept rate", len, 11 * OVS);
    cfg_short = 1'b0; cfg_par_on = 1'b1; cfg_rate = 4'd0;
    idle(2);

    // R6 R7: queue one word, drop a third
    pulse_load(8'hA5, 1'b1);
    @(negedge clk);
    chk("R6 buffer taken", int'(buf_empty), 0);
    @(negedge clk);
    chk("R7 moved to shifter", int'(buf_empty), 1);
    chk("R7 busy on move", int'(busy), 1);
    pulse_load(8'h3C, 1'b0);
    pulse_load(8'hFF, 1'b1);
    @(negedge clk);
    chk("R6 buffer still full", int'(buf_empty), 0);
    cnt = 0;
    while (busy === 1'b1 && cnt < 2000) begin @(negedge clk); cnt++; end
    @(negedge clk);
    chk("R7 back-to-back busy run", last_run, 2 * 11 * OVS);
    idle(4);
    @(negedge clk);
    chk("R6 ignored word never sent", int'(busy), 0);

    // R5: pulse coding at code 1 (D=2)
    cfg_irda = 1'b1; cfg_rate = 4'd1; cfg_par_on = 1'b0;
    idle(2);
    @(negedge clk);
    chk("R5 idle low", int'(tx), 0);
    pulse_load(8'h0F, 1'b0);
    cnt = 0;
    @(negedge clk);
    while (busy !== 1'b1 && cnt < 50) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (tx === 1'b1 && cnt < 100) begin cnt++; @(negedge clk); end
    chk("R5 pulse width", cnt, PULSE * 2);
    repeat (OVS*2 + 4 - cnt) @(negedge clk);
    chk("R5 one bit dark", int'(tx), 0);
    cnt = 0;
    while (busy === 1'b1 && cnt < 2000) begin @(negedge clk); cnt++; end
    cfg_irda = 1'b0; cfg_rate = 4'd0;
    idle(2);

    // R8: abort mid-frame with a queued word, loads ignored meanwhile
    pulse_load(8'h00, 1'b0);
    pulse_load(8'h00, 1'b0);
    idle(40);
    shdn = 1'b1;
    @(negedge clk);
    chk("R8 tx rest in same cycle", int'(tx), 1);
    step();
    @(negedge clk);
    chk("R8 busy cleared", int'(busy), 0);
    chk("R8 buffer flushed", int'(buf_empty), 1);
    pulse_load(8'h00, 1'b0);
    @(negedge clk);
    chk("R8 load ignored in shutdown", int'(buf_empty), 1);
    step(); shdn = 1'b0;
    idle(30);
    @(negedge clk);
    chk("R8 nothing resumes", int'(busy), 0);
    chk("R8 line at rest", int'(tx), 1);

    summary();
    $finish;
  end
endmodule